// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each. It takes several clock cycles and retires two multiplier bits per cycle. A one-cycle `start` pulse, given while the unit is idle, captures both operands. The unit then runs `WIDTH/2` recoding steps with `busy` held high. At the end it raises `done` for one cycle and presents the full `2*WIDTH`-bit signed product.

Each step reads a three-bit window: the two lowest bits of the multiplier register and the bit shifted out on the previous step (zero before the first step). From that window it adds zero, plus or minus the multiplicand, or plus or minus twice the multiplicand to a running sum. It then shifts the running sum and the multiplier register together right by two places, copying the sign bit into the vacated positions. The running sum carries two extra high bits, so that twice the most negative multiplicand still fits. The product is the low `WIDTH` bits of the running sum followed by the multiplier register.

Top module: `booth_mult_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`=0, `done`=0 and `product`=0.
- R2: A `start` that is high at a clock edge while `busy` is low captures `mcand` and `mplier`, and `busy` is high in the following cycle.
- R3: After a `start` is captured, exactly `WIDTH/2` steps run, so `busy` stays high for `WIDTH/2` cycles. `done` is high for exactly one cycle, the cycle in which `busy` first reads low again.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value. This holds for all operand pairs, including the most negative value on either or both inputs.
- R5: While `busy` is high, `start` and any change on `mcand`/`mplier` have no effect on the result or on the step count, and no new operation begins when the current one ends.
- R6: While `busy` is low and no `start` is captured, `product` holds its value.
- R7: The window {q1,q0,prev} selects the action: 000 and 111 add nothing; 001 and 010 add the multiplicand; 011 adds twice the multiplicand; 100 subtracts twice the multiplicand; 101 and 110 subtract the multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication (honoured only while idle) |
| mcand | input | WIDTH | Multiplicand, signed |
| mplier | input | WIDTH | Multiplier, signed |
| busy | output | 1 | High while recoding steps run |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed product |

## Verification
The handshake is checked on every cycle by the assertions:
- a captured start leads to busy;
- busy lasts exactly `WIDTH/2` cycles;
- done coincides with the falling edge of busy and lasts one cycle;
- the product is frozen while idle;
- reset clears the outputs.

The arithmetic itself can only be shown by the bench scenarios. These cover every operand pair at `WIDTH`=6, random and extreme pairs at `WIDTH`=16, and multiplier patterns chosen to exercise each of the eight recoding windows. The bench also covers the cases where a restart is ignored.

// File: rtl/booth_mult_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes nothing beyond being compiled before its users.
package booth_mult_pkg;

    // Action chosen by one three-bit recoding window
    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_ADD1 = 3'd1,
        ACT_ADD2 = 3'd2,
        ACT_SUB1 = 3'd3,
        ACT_SUB2 = 3'd4
    } booth_act_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-4 Booth recoder: maps the window {q1, q0, prev} to an add action.
// Assumes the window is presented with the highest multiplier bit first.
module booth_recode
    import booth_mult_pkg::*;
(
    input  logic [2:0] win,
    output booth_act_e act
);

    // Decode the eight windows into five actions
    always_comb begin
        unique case (win)
            3'b001, 3'b010: act = ACT_ADD1;
            3'b011:         act = ACT_ADD2;
            3'b100:         act = ACT_SUB2;
            3'b101, 3'b110: act = ACT_SUB1;
            default:        act = ACT_NONE;
        endcase
    end

endmodule

// File: rtl/booth_addend.sv
// Builds the signed addend (0, +-M, +-2M) widened to ACC_W bits.
// Assumes ACC_W = WIDTH + 2, which holds 2x the most negative multiplicand.
module booth_addend
    import booth_mult_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int ACC_W = WIDTH + 2
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_act_e       act,
    output logic [ACC_W-1:0] addend
);

    logic [ACC_W-1:0] m_ext;
    logic [ACC_W-1:0] m_dbl;

    // Sign-extend the multiplicand and form its double
    always_comb begin
        m_ext = {{(ACC_W-WIDTH){mcand[WIDTH-1]}}, mcand};
        m_dbl = {m_ext[ACC_W-2:0], 1'b0};
    end

    // Select the magnitude and apply negation for subtract actions
    always_comb begin
        unique case (act)
            ACT_ADD1: addend = m_ext;
            ACT_ADD2: addend = m_dbl;
            ACT_SUB1: addend = -m_ext;
            ACT_SUB2: addend = -m_dbl;
            default:  addend = '0;
        endcase
    end

endmodule

// File: rtl/booth_seq_ctrl.sv
// Step sequencer: accepts start while idle, runs STEPS steps, pulses done.
// Assumes STEPS >= 1; start during busy is discarded.
module booth_seq_ctrl #(
    parameter int STEPS = 8,
    parameter int CNT_W = $clog2(STEPS) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    logic [CNT_W-1:0] cnt;
    logic             last;

    // Decode load, step and final-step strobes
    always_comb begin
        load = start && !busy;
        step = busy;
        last = busy && (cnt == CNT_W'(STEPS - 1));
    end

    // Track busy, step count and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (step) begin
                cnt <= cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/booth_mult_seq.sv
// Sequential radix-4 Booth multiplier, WIDTH/2 steps per product.
// Assumes WIDTH is even; product is valid while done is high and is held
// until the next accepted start.
module booth_mult_seq
    import booth_mult_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int ACC_W = WIDTH + 2;
    localparam int STEPS = WIDTH / 2;

    logic [ACC_W-1:0] acc;
    logic [WIDTH-1:0] q_reg;
    logic             q_prev;
    logic [WIDTH-1:0] m_reg;
    logic             load;
    logic             step;
    booth_act_e       act;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] sum;

    booth_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .win (({q_reg[1:0], q_prev})),
        .act (act)
    );

    booth_addend #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_addend (
        .mcand  (m_reg),
        .act    (act),
        .addend (addend)
    );

    // Partial sum before the two-place shift
    always_comb begin
        sum = acc + addend;
    end

    // Capture the multiplicand on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_reg <= '0;
        end else if (load) begin
            m_reg <= mcand;
        end
    end

    // Load or arithmetic-shift the {acc, q_reg, q_prev} chain by two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            q_reg  <= '0;
            q_prev <= 1'b0;
        end else if (load) begin
            acc    <= '0;
            q_reg  <= mplier;
            q_prev <= 1'b0;
        end else if (step) begin
            acc    <= {{2{sum[ACC_W-1]}}, sum[ACC_W-1:2]};
            q_reg  <= {sum[1:0], q_reg[WIDTH-1:2]};
            q_prev <= q_reg[1];
        end
    end

    // Product is the low accumulator bits above the multiplier register
    always_comb begin
        product = {acc[WIDTH-1:0], q_reg};
    end

endmodule

// File: rtl/booth_mult_chk.sv
// Port-level protocol checker for booth_mult_seq, attached by bind.
// Assumes it sees the same clock and reset as the multiplier.
module booth_mult_chk #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int STEPS = WIDTH / 2;
    localparam int BC_W  = $clog2(STEPS + 1) + 1;

    logic [BC_W-1:0] busy_cycles;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cycles <= '0;
        end else if (busy) begin
            busy_cycles <= busy_cycles + 1'b1;
        end else begin
            busy_cycles <= '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && product == '0));

    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cycles == BC_W'(STEPS)));

    a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_done_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth_mult_seq booth_mult_chk #(.WIDTH(WIDTH)) u_booth_mult_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/test_booth_mult_seq.sv
// Directed bench for booth_mult_seq at WIDTH=16 and WIDTH=6.
module test_booth_mult_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    // WIDTH=16 instance
    logic        start16 = 1'b0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic        busy16;
    logic        done16;
    logic [31:0] prod16;

    booth_mult_seq #(.WIDTH(16)) i_booth_mult_seq (
        .clk(clk), .rst_n(rst_n), .start(start16), .mcand(a16), .mplier(b16),
        .busy(busy16), .done(done16), .product(prod16)
    );

    // WIDTH=6 instance
    logic        start6 = 1'b0;
    logic [5:0]  a6 = '0;
    logic [5:0]  b6 = '0;
    logic        busy6;
    logic        done6;
    logic [11:0] prod6;

    booth_mult_seq #(.WIDTH(6)) i_booth_mult_seq_w6 (
        .clk(clk), .rst_n(rst_n), .start(start6), .mcand(a6), .mplier(b6),
        .busy(busy6), .done(done6), .product(prod6)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One 16-bit multiplication; lat counts negedges from start release to done
    task automatic run16(input logic [15:0] x, input logic [15:0] y,
                         output longint p, output int lat);
        @(negedge clk);
        a16 = x; b16 = y; start16 = 1'b1;
        @(negedge clk);
        start16 = 1'b0;
        lat = 1;
        while (!done16 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        p = longint'($signed(prod16));
    endtask

    task automatic run6(input logic [5:0] x, input logic [5:0] y,
                        output longint p, output int lat);
        @(negedge clk);
        a6 = x; b6 = y; start6 = 1'b1;
        @(negedge clk);
        start6 = 1'b0;
        lat = 1;
        while (!done6 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        p = longint'($signed(prod6));
    endtask

    task automatic t_reset();
        chk(!busy16 && !done16, "R1 busy/done after reset", {busy16, done16}, 0);
        chk(prod16 == '0, "R1 product after reset", prod16, 0);
        chk(!busy6 && !done6 && prod6 == '0, "R1 w6 outputs after reset", prod6, 0);
    endtask

    task automatic t_accept();
        @(negedge clk);
        a16 = 16'd3; b16 = 16'd5; start16 = 1'b1;
        @(negedge clk);
        start16 = 1'b0;
        chk(busy16, "R2 busy after accepted start", busy16, 1);
        while (!done16) @(negedge clk);
        chk($signed(prod16) == 15, "R2 captured operands", $signed(prod16), 15);
    endtask

    task automatic t_timing();
        longint p;
        int lat;
        run16(16'd100, -16'sd7, p, lat);
        chk(lat == 9, "R3 latency WIDTH=16", lat, 9);
        chk(!busy16, "R3 busy low with done", busy16, 0);
        @(negedge clk);
        chk(!done16, "R3 done is one cycle", done16, 0);
        run6(6'd5, 6'd3, p, lat);
        chk(lat == 4, "R3 latency WIDTH=6", lat, 4);
    endtask

    task automatic t_exhaustive6();
        longint p;
        int lat;
        for (int i = -32; i < 32; i++) begin
            for (int j = -32; j < 32; j++) begin
                run6(6'(i), 6'(j), p, lat);
                chk(p == longint'(i * j) && lat == 4, "R4 exhaustive WIDTH=6", p, i * j);
            end
        end
    endtask

    task automatic t_extremes16();
        longint p;
        int lat;
        logic [15:0] vals [6] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0001, 16'h8001};
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                run16(vals[i], vals[j], p, lat);
                chk(p == longint'($signed(vals[i])) * longint'($signed(vals[j])),
                    "R4 extreme operands", p,
                    longint'($signed(vals[i])) * longint'($signed(vals[j])));
            end
        end
    endtask

    task automatic t_random16();
        longint p;
        int lat;
        for (int k = 0; k < 400; k++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            run16(x, y, p, lat);
            chk(p == longint'($signed(x)) * longint'($signed(y)), "R4 random WIDTH=16",
                p, longint'($signed(x)) * longint'($signed(y)));
        end
    endtask

    // Multiplier patterns that walk through all eight recoding windows
    task automatic t_codes16();
        longint p;
        int lat;
        logic [15:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA,
                                  16'h3333, 16'hCCCC, 16'h7FFF, 16'h8000};
        logic [15:0] mc [4] = '{16'd12345, -16'sd7, 16'h8000, 16'h7FFF};
        foreach (mc[i]) begin
            foreach (pats[j]) begin
                run16(mc[i], pats[j], p, lat);
                chk(p == longint'($signed(mc[i])) * longint'($signed(pats[j])),
                    "R7 recoding window patterns", p,
                    longint'($signed(mc[i])) * longint'($signed(pats[j])));
            end
        end
    endtask

    task automatic t_ignore_start();
        int lat;
        @(negedge clk);
        a16 = 16'd1234; b16 = -16'sd321; start16 = 1'b1;
        @(negedge clk);
        start16 = 1'b0;
        lat = 1;
        repeat (2) begin
            @(negedge clk);
            lat++;
        end
        a16 = 16'd9; b16 = 16'd9; start16 = 1'b1;
        @(negedge clk);
        lat++;
        start16 = 1'b0;
        a16 = 16'h7777; b16 = 16'h1111;
        while (!done16 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 9, "R5 latency unchanged by start during busy", lat, 9);
        chk($signed(prod16) == -396114, "R5 result unchanged by start during busy",
            $signed(prod16), -396114);
        @(negedge clk);
        chk(!busy16, "R5 no restart after ignored start", busy16, 0);
    endtask

    task automatic t_hold();
        longint p;
        int lat;
        run16(-16'sd300, 16'd41, p, lat);
        a16 = 16'h1234; b16 = 16'h4321;
        repeat (5) @(negedge clk);
        chk($signed(prod16) == -12300, "R6 product held while idle", $signed(prod16), -12300);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_accept();
        t_timing();
        t_ignore_start();
        t_hold();
        t_codes16();
        t_extremes16();
        t_random16();
        t_exhaustive6();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule